// File: doc/BRIEF.md
# PLL Output Rate Decoder

This block works out the output frequency of one PLL and divider channel from three configuration words: the channel's divider control word, its PLL word and the chip-wide boot word. The boot word carries a two-bit clock source field for each channel. The block uses that field to choose one of four base rates, which arrive as input ports. It decodes the pre-divider, post-divider and multiplier fields. It then applies the formula set by the bypass, mode and half-multiply bits and returns the result as an unsigned integer.

A one-cycle `start` pulse latches the inputs. The block then runs a restoring divider, one quotient bit per cycle, and raises `done` for one cycle. The result stays on `rate` until the next run finishes. Software or a boot sequencer can use the block to report clock rates without doing the arithmetic itself.

Top module: `pll_rate_calc`

## Requirements
- R1: The total divisor is (ctrlWord[20:16] + 1) × (ctrlWord[4:0] + 1), so each field gives 1 to 32, and `rate` is the selected numerator divided by this divisor, truncated toward zero.
- R2: The multiplier is pllWord[15:12] + 1, which ranges from 1 to 16.
- R3: `chanSel` chooses where the source field sits in bootWord. The encodings are 0→bits 15:14, 1→bits 17:16, 2→bits 19:18 and 3→bits 23:22. Field code 0 selects `busRate`, 1 selects `refRate`, 2 selects `xtalRate` and 3 selects `cpuRate`.
- R4: When bootWord[5] is 1, the numerator is the base rate.
- R5: Otherwise, when pllWord[0] is 0, the numerator is the base rate shifted right by 2 if the multiplier is 16, and by 1 for any other multiplier.
- R6: Otherwise, when pllWord[11] and pllWord[1] are both 1, the numerator depends on the multiplier. An odd multiplier gives (base × mul) >> 1. An even multiplier gives (base × (mul − 1)) >> 2.
- R7: Otherwise, a multiplier of 16 makes the numerator equal to the base rate.
- R8: Otherwise, the numerator is base × mul, held without overflow in 40 bits.
- R9: The rules take priority in this order: R4, then R5, then R6, then R7, then R8.
- R10: Take the clock edge that samples `start` high while idle as edge 1. `done` goes high after edge 42 and stays high for exactly one cycle. `rate` takes its new value at that same edge and holds it until the next completion.
- R11: The block latches all inputs on the accepted start. A `start` pulse while `busy` is high is ignored, and so are input changes during a run.
- R12: After reset, `busy` and `done` are 0 and `rate` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation when idle |
| chanSel | input | 2 | Channel whose source field is used |
| bootWord | input | 32 | Boot configuration word |
| ctrlWord | input | 32 | Channel divider control word |
| pllWord | input | 32 | Channel PLL word |
| busRate | input | 32 | Base rate for source code 0 |
| refRate | input | 32 | Base rate for source code 1 |
| xtalRate | input | 32 | Base rate for source code 2 |
| cpuRate | input | 32 | Base rate for source code 3 |
| busy | output | 1 | A computation is in progress |
| done | output | 1 | One-cycle completion strobe |
| rate | output | 40 | Computed output rate |

## Verification
Most internal faults show up on `rate` in the cycle when `done` rises, 42 cycles after the accepted start:
- A wrong source field or field offset gives a visibly wrong rate.
- A swapped rule priority gives a visibly wrong rate.
- A remainder that is not restored gives a quotient that is wrong, usually in its low bits.

A step counter that is off by one moves `done` away from cycle 42. A control state that re-arms on a busy `start` produces a second `done` or a rate from the wrong inputs.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;
  localparam int WORD_W = 32;
  localparam int FIELD_W = 5;
  localparam int MUL_FIELD_W = 4;
  localparam int PRE_LSB = 16;
  localparam int POST_LSB = 0;
  localparam int MUL_LSB = 12;
  localparam int BYPASS_BIT = 5;
  localparam int MODE_BIT = 0;
  localparam int HALF_BIT_A = 11;
  localparam int HALF_BIT_B = 1;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } rateStrobes_t;
endpackage

// File: rtl/rate_ctrl.sv
module rate_ctrl #(
  parameter int STEPS = 40
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  output pll_rate_pkg::rateStrobes_t strobes,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(STEPS + 1);

  typedef enum logic [1:0] {IDLE, RUN, FIN} state_t;
  state_t state;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strobes.load = (state == IDLE) && start;
    strobes.step = (state == RUN);
    strobes.finish = (state == FIN);
  end

  assign busy = (state != IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= IDLE;
      stepCnt <= '0;
      done <= 1'b0;
    end else begin
      done <= strobes.finish;
      case (state)
        IDLE: if (start) begin
          state <= RUN;
          stepCnt <= '0;
        end
        RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CNT_W'(STEPS - 1)) state <= FIN;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |-> !strobes.load);
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.step, strobes.finish}));
endmodule

// File: rtl/rate_datapath.sv
module rate_datapath #(
  parameter int BASE_W = 32,
  parameter int PROD_W = 40
) (
  input  logic clk,
  input  logic rstN,
  input  pll_rate_pkg::rateStrobes_t strobes,
  input  logic [1:0] chanSel,
  input  logic [pll_rate_pkg::WORD_W-1:0] bootWord,
  input  logic [pll_rate_pkg::WORD_W-1:0] ctrlWord,
  input  logic [pll_rate_pkg::WORD_W-1:0] pllWord,
  input  logic [BASE_W-1:0] busRate,
  input  logic [BASE_W-1:0] refRate,
  input  logic [BASE_W-1:0] xtalRate,
  input  logic [BASE_W-1:0] cpuRate,
  output logic [PROD_W-1:0] rate
);
  import pll_rate_pkg::*;
  localparam int DIVF_W = FIELD_W + 1;
  localparam int DIVR_W = 2 * DIVF_W - 1;
  localparam int MUL_W = MUL_FIELD_W + 1;

  logic [1:0] srcCode;
  logic [BASE_W-1:0] baseRate;
  logic [DIVF_W-1:0] preDiv, postDiv;
  logic [MUL_W-1:0] mulVal;
  logic [PROD_W-1:0] baseExt, prodFull, prodLess, numer;
  logic [DIVR_W-1:0] divisorVal;

  always_comb begin
    case (chanSel)
      2'd0: srcCode = bootWord[15:14];
      2'd1: srcCode = bootWord[17:16];
      2'd2: srcCode = bootWord[19:18];
      default: srcCode = bootWord[23:22];
    endcase
    case (srcCode)
      2'd0: baseRate = busRate;
      2'd1: baseRate = refRate;
      2'd2: baseRate = xtalRate;
      default: baseRate = cpuRate;
    endcase
    preDiv = {1'b0, ctrlWord[PRE_LSB +: FIELD_W]} + 1'b1;
    postDiv = {1'b0, ctrlWord[POST_LSB +: FIELD_W]} + 1'b1;
    divisorVal = DIVR_W'(preDiv) * DIVR_W'(postDiv);
    mulVal = {1'b0, pllWord[MUL_LSB +: MUL_FIELD_W]} + 1'b1;
    baseExt = PROD_W'(baseRate);
    prodFull = baseExt * PROD_W'(mulVal);
    prodLess = baseExt * PROD_W'(mulVal - 1'b1);
    if (bootWord[BYPASS_BIT])
      numer = baseExt;
    else if (!pllWord[MODE_BIT])
      numer = mulVal[MUL_W-1] ? (baseExt >> 2) : (baseExt >> 1);
    else if (pllWord[HALF_BIT_A] && pllWord[HALF_BIT_B])
      numer = mulVal[0] ? (prodFull >> 1) : (prodLess >> 2);
    else if (mulVal[MUL_W-1])
      numer = baseExt;
    else
      numer = prodFull;
  end

  logic [PROD_W-1:0] quoReg;
  logic [DIVR_W-1:0] remReg, divReg;
  logic [DIVR_W:0] trial;

  assign trial = {remReg, quoReg[PROD_W-1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quoReg <= '0;
      remReg <= '0;
      divReg <= '0;
      rate <= '0;
    end else begin
      if (strobes.load) begin
        quoReg <= numer;
        remReg <= '0;
        divReg <= divisorVal;
      end else if (strobes.step) begin
        if (trial >= {1'b0, divReg}) begin
          remReg <= DIVR_W'(trial - {1'b0, divReg});
          quoReg <= {quoReg[PROD_W-2:0], 1'b1};
        end else begin
          remReg <= trial[DIVR_W-1:0];
          quoReg <= {quoReg[PROD_W-2:0], 1'b0};
        end
      end
      if (strobes.finish) rate <= quoReg;
    end
  end

  assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |-> (remReg < divReg));
  assert_divisor_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> $stable(divReg));
  assert_rate_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finish |=> $stable(rate));
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
  parameter int BASE_W = 32,
  parameter int PROD_W = BASE_W + 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [1:0] chanSel,
  input  logic [31:0] bootWord,
  input  logic [31:0] ctrlWord,
  input  logic [31:0] pllWord,
  input  logic [BASE_W-1:0] busRate,
  input  logic [BASE_W-1:0] refRate,
  input  logic [BASE_W-1:0] xtalRate,
  input  logic [BASE_W-1:0] cpuRate,
  output logic busy,
  output logic done,
  output logic [PROD_W-1:0] rate
);
  pll_rate_pkg::rateStrobes_t strobes;

  rate_ctrl #(.STEPS(PROD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobes(strobes), .busy(busy), .done(done)
  );

  rate_datapath #(.BASE_W(BASE_W), .PROD_W(PROD_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .chanSel(chanSel),
    .bootWord(bootWord), .ctrlWord(ctrlWord), .pllWord(pllWord),
    .busRate(busRate), .refRate(refRate), .xtalRate(xtalRate),
    .cpuRate(cpuRate), .rate(rate)
  );
endmodule

// File: tb/tb_pll_rate_calc.sv
module tb_pll_rate_calc;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] chanSel = '0;
  logic [31:0] bootWord = '0, ctrlWord = '0, pllWord = '0;
  logic [31:0] busRate = '0, refRate = '0, xtalRate = '0, cpuRate = '0;
  logic busy, done;
  logic [39:0] rate;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pll_rate_calc dut (.*);

  function automatic longint unsigned expRate(logic [1:0] sel, logic [31:0] bw,
      logic [31:0] cw, logic [31:0] pw, logic [31:0] b0, logic [31:0] b1,
      logic [31:0] b2, logic [31:0] b3);
    int sh;
    longint unsigned base, mul, n, dv;
    sh = (sel == 0) ? 14 : (sel == 1) ? 16 : (sel == 2) ? 18 : 22;
    case ((bw >> sh) & 3)
      0: base = b0;
      1: base = b1;
      2: base = b2;
      default: base = b3;
    endcase
    dv = (((cw >> 16) & 31) + 1) * ((cw & 31) + 1);
    mul = ((pw >> 12) & 15) + 1;
    if (bw[5]) n = base;
    else if (!pw[0]) n = base >> (mul / 16 + 1);
    else if (pw[11] && pw[1]) n = (mul % 2 == 1) ? (base * mul) >> 1 : (base * (mul - 1)) >> 2;
    else if (mul == 16) n = base;
    else n = base * mul;
    return n / dv;
  endfunction

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic runCase(string tag, logic [1:0] s, logic [31:0] bw, logic [31:0] cw,
      logic [31:0] pw, logic [31:0] b0, logic [31:0] b1, logic [31:0] b2,
      logic [31:0] b3, bit disturb);
    int lat;
    longint unsigned exp;
    exp = expRate(s, bw, cw, pw, b0, b1, b2, b3);
    @(negedge clk);
    chanSel = s; bootWord = bw; ctrlWord = cw; pllWord = pw;
    busRate = b0; refRate = b1; xtalRate = b2; cpuRate = b3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      if (disturb && lat == 5) begin
        start = 1'b1;
        bootWord = ~bw; ctrlWord = ~cw; pllWord = ~pw; chanSel = ~s;
        busRate = ~b0; refRate = ~b1;
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check({tag, " rate"}, rate, exp);
    check("R10 latency", lat, 42);
    @(negedge clk);
    check("R10 done single cycle", done, 0);
    check("R10 rate held", rate, exp);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R12 busy", busy, 0);
    check("R12 done", done, 0);
    check("R12 rate", rate, 0);
    rstN = 1'b1;
    // R4 bypass: base 100000000, div 2*3
    runCase("R4 bypass", 2'd0, 32'h20 | (32'd1 << 14), 32'h0001_0002, 32'h0000_F003,
            32'd1, 32'd100000000, 32'd3, 32'd4, 0);
    // R5 mode clear, mul 16 -> >>2 ; mul 3 -> >>1
    runCase("R5 mode clear mul16", 2'd1, 32'd2 << 16, 32'h0, 32'h0000_F000,
            32'd1, 32'd2, 32'd1000003, 32'd4, 0);
    runCase("R5 mode clear mul3", 2'd1, 32'd2 << 16, 32'h0000_0004, 32'h0000_2002,
            32'd1, 32'd2, 32'd1000003, 32'd4, 0);
    // R6 half multiply odd mul 7, even mul 8
    runCase("R6 half odd", 2'd2, 32'd3 << 18, 32'h0000_0000, 32'h0000_6803,
            32'd1, 32'd2, 32'd3, 32'd25000001, 0);
    runCase("R6 half even", 2'd2, 32'd3 << 18, 32'h0000_0000, 32'h0000_7803,
            32'd1, 32'd2, 32'd3, 32'd25000001, 0);
    // R7 mul 16 gives base
    runCase("R7 mul16", 2'd3, 32'd0, 32'h0002_0000, 32'h0000_F001,
            32'd125000000, 32'd2, 32'd3, 32'd4, 0);
    // R8 max numerator, R1 max divisor 1024
    runCase("R8 R1 max", 2'd3, 32'd0, 32'h001F_001F, 32'h0000_E001,
            32'hFFFF_FFFF, 32'd2, 32'd3, 32'd4, 0);
    runCase("R8 R2 big", 2'd0, 32'd0, 32'h0, 32'h0000_E001,
            32'hFFFF_FFFF, 32'd2, 32'd3, 32'd4, 0);
    // R9 priority: bypass wins over all; mode clear wins over half
    runCase("R9 bypass first", 2'd0, 32'h20, 32'h0, 32'h0000_5802,
            32'd777777, 32'd2, 32'd3, 32'd4, 0);
    runCase("R9 mode before half", 2'd0, 32'h0, 32'h0, 32'h0000_5802,
            32'd777777, 32'd2, 32'd3, 32'd4, 0);
    // R11 start while busy and input changes ignored
    runCase("R11 busy ignore", 2'd1, 32'd1 << 16, 32'h0003_0004, 32'h0000_4001,
            32'd5, 32'd90000000, 32'd7, 32'd8, 1);
    for (int i = 0; i < 200; i++) begin
      runCase("R1 R2 R3 R9 random", 2'($urandom), $urandom, $urandom, $urandom,
              $urandom, $urandom, $urandom, $urandom, (i % 17) == 0);
    end
    repeat (5) @(negedge clk);
    check("R10 no extra done", done, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule